// File: doc/BRIEF.md
# Partial-Array Refresh Section Scheduler

This block issues hidden refresh requests for a memory whose 20-bit word address space is cut into four equal quarters, named by the top two address bits. A placement field (bottom or top) and a fraction field (full, three quarters, half, one quarter) pick which quarters hold data. From these fields, the sleep state and the power-down choice, the block works out the set of quarters to refresh. A row pointer then walks only through that set, jumping over quarters that are switched off.

A free-running timebase tick drives an interval counter. The number of ticks between requests comes from one of four temperature codes, and hotter settings give shorter intervals. Each request stays high with its row address until the memory controller returns a done pulse. The pointer then moves to the next row. In reduced-size operation the same quarter set also bounds the legal address space, and the block stops any access that falls outside it.

Top module: `psr_sched_top`

## Requirements
- R1: With bottom placement (`top_sel_i`=0), fraction code 2'b11 keeps quarter 0, 2'b10 keeps quarters 0 and 1, and 2'b01 keeps quarters 0, 1 and 2. The refresh address section is `ref_addr_o[ROW_W+1:ROW_W]`.
- R2: With top placement (`top_sel_i`=1), fraction code 2'b11 keeps quarter 3, 2'b10 keeps quarters 2 and 3, and 2'b01 keeps quarters 1, 2 and 3. Fraction 2'b00 keeps all four quarters in either placement.
- R3: While `sleep_i`=0 and `rms_en_i`=0, all four quarters are refreshed regardless of the placement and fraction fields. While `sleep_i`=1 with `dpd_en_i`=0, or while `rms_en_i`=1, only the kept quarters are refreshed.
- R4: While `sleep_i`=1 and `dpd_en_i`=1, no refresh request is raised, and a pending request drops on the next clock edge.
- R5: A request is raised on the edge of every Nth `tick_i`, where N is 2, 3, 5 or 8 ticks (parameters) for temperature codes 2'b11 (hottest), 2'b00, 2'b01 and 2'b10 (coldest). The interval counter starts at zero after reset.
- R6: Refresh rows run from row 0 to row 2^ROW_W-1 inside a quarter. After the last row of a kept quarter comes row 0 of the next kept quarter in ascending order, wrapping from 3 to 0, with skipped quarters left out. If the pointer rests in a quarter that is no longer kept, the address shown is row 0 of the next kept quarter.
- R7: `ref_req_o` stays high with a stable address until a cycle in which `ack_i`=1. Each such ack moves the pointer by exactly one row. A tick interval that ends while a request is still pending raises no extra request.
- R8: With `rms_en_i`=1, an access whose address bits [19:18] name a quarter that is not kept raises `acc_oor_o` and holds `acc_go_o` low. Any other valid access drives `acc_go_o` high with `acc_oor_o` low.
- R9: After reset, `ref_req_o` is 0 and `ref_addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Standby sleep asserted |
| dpd_en_i | input | 1 | Sleep means deep power down (1) or partial refresh (0) |
| rms_en_i | input | 1 | Reduced-size operation |
| top_sel_i | input | 1 | Kept quarters taken from top (1) or bottom (0) |
| frac_i | input | 2 | Kept fraction code |
| temp_i | input | 2 | Temperature code |
| tick_i | input | 1 | Timebase tick |
| ack_i | input | 1 | Refresh done |
| acc_valid_i | input | 1 | Access request |
| acc_addr_i | input | 20 | Access word address |
| ref_req_o | output | 1 | Refresh request |
| ref_addr_o | output | ROW_W+2 | Refresh address: quarter and row |
| acc_go_o | output | 1 | Access issued |
| acc_oor_o | output | 1 | Access outside active space |

## Verification
The bench exercises all seven placement and fraction combinations in partial-sleep mode. It covers the three-quarter cases on both sides, which show whether the pointer jumps the gap at quarter 3 or quarter 0. It also runs full refresh with the fields set to narrow values, which shows that masking is not applied while awake. All four temperature codes are tried with ticks every cycle and every third cycle, and with immediate and delayed acks, to tell interval timing apart from absorbed overlapping intervals. It also covers deep power down entered with a request pending, and reduced-size accesses that land in each quarter on both sides of the kept boundary.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int SEC_N = 4;
  localparam int SEC_W = 2;

  typedef enum logic [1:0] {
    FR_FULL = 2'b00,
    FR_3Q   = 2'b01,
    FR_HALF = 2'b10,
    FR_1Q   = 2'b11
  } frac_e;

  typedef enum logic [1:0] {
    TMP_70 = 2'b00,
    TMP_45 = 2'b01,
    TMP_15 = 2'b10,
    TMP_85 = 2'b11
  } temp_e;

  // first kept section at or after s, cyclic
  function automatic logic [SEC_W-1:0] next_kept(logic [SEC_W-1:0] s, logic [SEC_N-1:0] m);
    logic [SEC_W-1:0] r;
    logic             hit;
    r   = s;
    hit = 1'b0;
    for (int k = 0; k < SEC_N; k++) begin
      if (!hit && m[s + SEC_W'(k)]) begin
        r   = s + SEC_W'(k);
        hit = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/psr_sec_mask.sv
module psr_sec_mask
  import psr_pkg::*;
(
  input  logic             sleep_i,
  input  logic             dpd_en_i,
  input  logic             rms_en_i,
  input  logic             top_sel_i,
  input  logic [1:0]       frac_i,
  output logic [SEC_N-1:0] keep_o,
  output logic [SEC_N-1:0] ref_mask_o
);
  always_comb begin
    unique case (frac_e'(frac_i))
      FR_3Q:   keep_o = top_sel_i ? 4'b1110 : 4'b0111;
      FR_HALF: keep_o = top_sel_i ? 4'b1100 : 4'b0011;
      FR_1Q:   keep_o = top_sel_i ? 4'b1000 : 4'b0001;
      default: keep_o = 4'b1111;
    endcase
  end

  always_comb begin
    if (sleep_i && dpd_en_i)      ref_mask_o = '0;
    else if (sleep_i || rms_en_i) ref_mask_o = keep_o;
    else                          ref_mask_o = '1;
  end

  always_comb begin
    assert_keep_nonzero_R1: assert (keep_o != '0);
  end
endmodule

// File: rtl/psr_timer.sv
module psr_timer
  import psr_pkg::*;
#(
  parameter int IVAL_85 = 2,
  parameter int IVAL_70 = 3,
  parameter int IVAL_45 = 5,
  parameter int IVAL_15 = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] temp_i,
  output logic       due_o
);
  localparam int IMAX_A = (IVAL_85 > IVAL_70) ? IVAL_85 : IVAL_70;
  localparam int IMAX_B = (IVAL_45 > IVAL_15) ? IVAL_45 : IVAL_15;
  localparam int IMAX   = (IMAX_A > IMAX_B) ? IMAX_A : IMAX_B;
  localparam int CNT_W  = $clog2(IMAX + 1);

  logic [CNT_W-1:0] cnt_q, last_c;

  always_comb begin
    unique case (temp_e'(temp_i))
      TMP_85:  last_c = CNT_W'(IVAL_85 - 1);
      TMP_70:  last_c = CNT_W'(IVAL_70 - 1);
      TMP_45:  last_c = CNT_W'(IVAL_45 - 1);
      default: last_c = CNT_W'(IVAL_15 - 1);
    endcase
  end

  assign due_o = tick_i && (cnt_q >= last_c);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= due_o ? '0 : cnt_q + 1'b1;
  end

  assert_due_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    due_o |=> !due_o);
  assert_cnt_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/psr_stepper.sv
module psr_stepper
  import psr_pkg::*;
#(
  parameter int ROW_W = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [SEC_N-1:0]       mask_i,
  input  logic                   adv_i,
  output logic [SEC_W+ROW_W-1:0] addr_o
);
  localparam logic [ROW_W-1:0] ROW_LAST = '1;

  logic [SEC_W-1:0] sec_q, eff_sec;
  logic [ROW_W-1:0] row_q, eff_row;

  always_comb begin
    if (mask_i[sec_q]) begin
      eff_sec = sec_q;
      eff_row = row_q;
    end else begin
      eff_sec = next_kept(sec_q + 1'b1, mask_i);
      eff_row = '0;
    end
  end

  assign addr_o = {eff_sec, eff_row};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      row_q <= '0;
    end else if (adv_i) begin
      if (eff_row == ROW_LAST) begin
        sec_q <= next_kept(eff_sec + 1'b1, mask_i);
        row_q <= '0;
      end else begin
        sec_q <= eff_sec;
        row_q <= eff_row + 1'b1;
      end
    end
  end

  assert_row_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (row_q == '0) || (row_q == $past(eff_row) + 1'b1));
  assert_hold_still_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(sec_q) && $stable(row_q));
endmodule

// File: rtl/psr_sched_top.sv
module psr_sched_top
  import psr_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int ROW_W   = 3,
  parameter int IVAL_85 = 2,
  parameter int IVAL_70 = 3,
  parameter int IVAL_45 = 5,
  parameter int IVAL_15 = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sleep_i,
  input  logic                   dpd_en_i,
  input  logic                   rms_en_i,
  input  logic                   top_sel_i,
  input  logic [1:0]             frac_i,
  input  logic [1:0]             temp_i,
  input  logic                   tick_i,
  input  logic                   ack_i,
  input  logic                   acc_valid_i,
  input  logic [ADDR_W-1:0]      acc_addr_i,
  output logic                   ref_req_o,
  output logic [SEC_W+ROW_W-1:0] ref_addr_o,
  output logic                   acc_go_o,
  output logic                   acc_oor_o
);
  logic [SEC_N-1:0] keep, ref_mask;
  logic             due, adv, any_on, req_q;
  logic [SEC_W-1:0] acc_sec;

  psr_sec_mask u_mask (
    .sleep_i    (sleep_i),
    .dpd_en_i   (dpd_en_i),
    .rms_en_i   (rms_en_i),
    .top_sel_i  (top_sel_i),
    .frac_i     (frac_i),
    .keep_o     (keep),
    .ref_mask_o (ref_mask)
  );

  psr_timer #(
    .IVAL_85 (IVAL_85),
    .IVAL_70 (IVAL_70),
    .IVAL_45 (IVAL_45),
    .IVAL_15 (IVAL_15)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .temp_i (temp_i),
    .due_o  (due)
  );

  assign any_on = |ref_mask;
  assign adv    = req_q && ack_i && any_on;

  psr_stepper #(.ROW_W(ROW_W)) u_step (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mask_i (ref_mask),
    .adv_i  (adv),
    .addr_o (ref_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             req_q <= 1'b0;
    else if (!any_on)        req_q <= 1'b0;
    else if (due)            req_q <= 1'b1;
    else if (req_q && ack_i) req_q <= 1'b0;
  end
  assign ref_req_o = req_q;

  assign acc_sec   = acc_addr_i[ADDR_W-1 -: SEC_W];
  assign acc_oor_o = acc_valid_i && rms_en_i && !keep[acc_sec];
  assign acc_go_o  = acc_valid_i && !acc_oor_o;

  assert_dpd_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && dpd_en_i) |=> !ref_req_o);
  assert_req_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_o && !ack_i && any_on) |=> ref_req_o);
  assert_addr_kept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_o && any_on) |-> ref_mask[ref_addr_o[SEC_W+ROW_W-1 -: SEC_W]]);
  assert_oor_block_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_oor_o |-> !acc_go_o);
  assert_awake_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && !rms_en_i) |-> (ref_mask == '1));
endmodule

// File: tb/psr_sched_top_tb_top.sv
module psr_sched_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 3;
  localparam int ROWS  = 1 << ROW_W;
  localparam int I85 = 2, I70 = 3, I45 = 5, I15 = 8;

  logic clk = 0, rst_n = 0;
  logic sleep = 0, dpd_en = 0, rms_en = 0, top_sel = 0, tick = 0, ack = 0, acc_valid = 0;
  logic [1:0] frac = 0, temp = 2'b11;
  logic [19:0] acc_addr = 0;
  logic ref_req, acc_go, acc_oor;
  logic [ROW_W+1:0] ref_addr;

  int errs = 0, chks = 0, cyc = 0, tick_div = 1, ack_lat = 0, req_age = 0;
  string tag = "R9";
  int m_tcnt = 0, m_req = 0, m_sec = 0, m_row = 0;
  bit done = 0;

  psr_sched_top #(.ROW_W(ROW_W), .IVAL_85(I85), .IVAL_70(I70), .IVAL_45(I45), .IVAL_15(I15)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sleep_i(sleep), .dpd_en_i(dpd_en), .rms_en_i(rms_en),
    .top_sel_i(top_sel), .frac_i(frac), .temp_i(temp), .tick_i(tick), .ack_i(ack),
    .acc_valid_i(acc_valid), .acc_addr_i(acc_addr), .ref_req_o(ref_req), .ref_addr_o(ref_addr),
    .acc_go_o(acc_go), .acc_oor_o(acc_oor));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit kept(int s);
    int n = (frac == 0) ? 4 : 4 - int'(frac);
    return top_sel ? (s >= 4 - n) : (s < n);
  endfunction
  function automatic bit rkeep(int s);
    if (sleep && dpd_en) return 0;
    if (sleep || rms_en) return kept(s);
    return 1;
  endfunction
  function automatic bit any_r();
    for (int s = 0; s < 4; s++) if (rkeep(s)) return 1;
    return 0;
  endfunction
  function automatic int after(int s); // first kept section strictly after s
    for (int k = 1; k <= 4; k++) if (rkeep((s + k) % 4)) return (s + k) % 4;
    return s;
  endfunction
  function automatic int interval();
    case (temp) 2'b11: return I85; 2'b00: return I70; 2'b01: return I45; default: return I15; endcase
  endfunction
  function automatic int eff_addr();
    if (rkeep(m_sec)) return m_sec * ROWS + m_row;
    return after(m_sec) * ROWS;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tcnt = 0; m_req = 0; m_sec = 0; m_row = 0;
    end else begin
      bit due, on;
      int ea;
      on  = any_r();
      due = tick && (m_tcnt >= interval() - 1);
      if (tick) m_tcnt = due ? 0 : m_tcnt + 1;
      if (m_req && ack && on) begin
        ea = eff_addr();
        if (ea % ROWS == ROWS - 1) begin m_sec = after(ea / ROWS); m_row = 0; end
        else begin m_sec = ea / ROWS; m_row = ea % ROWS + 1; end
      end
      if (!on) m_req = 0;
      else if (due) m_req = 1;
      else if (m_req && ack) m_req = 0;
    end
  end

  task automatic check(bit ok, string rq, string what, int act, int exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      check(ref_req == m_req[0], tag, "ref_req", ref_req, m_req);
      if (any_r()) check(int'(ref_addr) == eff_addr(), tag, "ref_addr", ref_addr, eff_addr());
      tick = (cyc % tick_div) == 0;
      if (ref_req) begin
        req_age++;
        ack = req_age > ack_lat;
        if (ack) req_age = 0;
      end else begin
        req_age = 0; ack = 0;
      end
    end
  endtask

  task automatic access(logic [1:0] sec, string rq);
    bit exp_oor;
    @(negedge clk);
    acc_valid = 1; acc_addr = {sec, 18'h1A5};
    #1;
    exp_oor = rms_en && !kept(sec);
    check(acc_oor == exp_oor, rq, "acc_oor", acc_oor, exp_oor);
    check(acc_go == !exp_oor, rq, "acc_go", acc_go, !exp_oor);
    acc_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errs++; chks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    check(ref_req == 0, "R9", "reset req", ref_req, 0);
    check(ref_addr == 0, "R9", "reset addr", ref_addr, 0);
    rst_n = 1;
    // awake: fields ignored, full refresh
    tag = "R3"; frac = 2'b11; top_sel = 1; run(120);
    // temperatures, immediate and late acks
    tag = "R5";
    for (int t = 0; t < 4; t++) begin temp = 2'(t); run(60); end
    tick_div = 3; run(90); tick_div = 1;
    tag = "R7"; ack_lat = 9; temp = 2'b11; run(80); ack_lat = 0;
    // partial sleep, bottom then top
    sleep = 1;
    for (int s = 0; s < 2; s++) begin
      top_sel = s[0];
      for (int f = 0; f < 4; f++) begin
        frac = 2'(f);
        tag = (f == 1) ? "R6" : (s == 0 ? "R1" : "R2");
        run(100);
      end
    end
    // deep power down with a request pending
    tag = "R4"; ack_lat = 20; run(6); dpd_en = 1; run(60);
    check(ref_req == 0, "R4", "req in deep power down", ref_req, 0);
    ack_lat = 0; dpd_en = 0; sleep = 0; run(40);
    // reduced size
    tag = "R8"; rms_en = 1;
    for (int s = 0; s < 2; s++) begin
      top_sel = s[0];
      for (int f = 0; f < 4; f++) begin
        frac = 2'(f);
        for (int q = 0; q < 4; q++) access(2'(q), "R8");
        run(30);
      end
    end
    rms_en = 0; frac = 2'b11;
    for (int q = 0; q < 4; q++) access(2'(q), "R8");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule